// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a five-stage in-order pipeline and chooses the source of each of the two ALU operands. An older instruction may already have computed a value that the instruction now in execute needs, but not yet written it to the register file. In that case the unit takes the value from the pipeline register where it is held, and does not use the stale register-file read.

Two producers can supply a value. The first is the execute/memory pipeline register, which holds the ALU result of the instruction one slot ahead. The second is the memory/writeback pipeline register, which holds the value being written back by the instruction two slots ahead. An instruction three slots ahead needs no path of its own. The register file writes in the first half of a cycle and reads in the second half, so its read port already returns that value.

For each operand the unit drives a 2-bit select code and the selected 32-bit value. The logic is purely combinational, so both outputs are valid in the same cycle as the inputs.

Top module: `operand_fwd_unit`

## Requirements
- R1: When `xm_wr_en` is 1, `xm_dst` is nonzero and `xm_dst` equals `ex_src_a`, then `fwd_sel_a` is 2'b10 and `opnd_a` equals `xm_result`.
- R2: When `xm_wr_en` is 1, `xm_dst` is nonzero and `xm_dst` equals `ex_src_b`, then `fwd_sel_b` is 2'b10 and `opnd_b` equals `xm_result`.
- R3: When `mw_wr_en` is 1, `mw_dst` is nonzero, `mw_dst` equals the operand's source number and the R1/R2 condition for that operand is false, then the operand's select is 2'b01 and its value equals `mw_wdata`.
- R4: When both producers write the same nonzero register that an operand reads, the execute/memory result wins: the select is 2'b10 and the value is `xm_result`.
- R5: A producer whose destination is register 0 never causes forwarding, whatever its enable.
- R6: A producer whose write enable is 0 never causes forwarding, even when its destination matches.
- R7: Operands A and B are decided independently. Both may forward in the same cycle, from the same stage or from different stages.
- R8: When no forwarding condition holds, the select is 2'b00 and the operand equals its register-file read value (`rf_val_a` or `rf_val_b`). The code 2'b11 is never produced.
- R9: Outputs follow inputs combinationally within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | 5 | Register number of the first source of the instruction in execute |
| ex_src_b | input | 5 | Register number of the second source of the instruction in execute |
| rf_val_a | input | 32 | Register-file read value for the first source |
| rf_val_b | input | 32 | Register-file read value for the second source |
| xm_wr_en | input | 1 | Execute/memory producer writes a register |
| xm_dst | input | 5 | Execute/memory producer destination number |
| xm_result | input | 32 | Execute/memory producer ALU result |
| mw_wr_en | input | 1 | Memory/writeback producer writes a register |
| mw_dst | input | 5 | Memory/writeback producer destination number |
| mw_wdata | input | 32 | Memory/writeback data being written back |
| fwd_sel_a | output | 2 | Source select for operand A (00 register file, 01 memory/writeback, 10 execute/memory) |
| fwd_sel_b | output | 2 | Source select for operand B, same coding |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Two functions can apply in the same cycle: the execute/memory path and the memory/writeback path. They can meet on one operand, where priority decides the winner, or split across the two operands, where each operand must resolve independently of the other. The bench provokes both cases with a small instruction stream shifted through modelled pipeline slots, in chains such as three back-to-back writes to one register and an instruction that reads the same register as both sources. It also applies directed vectors that put the two producers on different operands. A behavioural reference model computes each cycle's expected codes and values with ordinary priority if/else logic, and the bench compares all four outputs against it on every clock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int N_OPND = 2;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_XM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  logic dst_live;

  always_comb begin
    dst_live = wr_en && (dst != '0);
    hit      = dst_live && (dst == src);
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     hit_xm,
  input  logic     hit_mw,
  output fwd_sel_e sel
);
  always_comb begin
    if (hit_xm)      sel = SEL_XM;
    else if (hit_mw) sel = SEL_MW;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] xm_val,
  input  logic [DATA_W-1:0] mw_val,
  output logic [DATA_W-1:0] out_val
);
  always_comb begin
    unique case (sel)
      SEL_XM:  out_val = xm_val;
      SEL_MW:  out_val = mw_val;
      default: out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
  import fwd_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DATA_W
) (
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [DW-1:0] rf_val_a,
  input  logic [DW-1:0] rf_val_b,
  input  logic          xm_wr_en,
  input  logic [RW-1:0] xm_dst,
  input  logic [DW-1:0] xm_result,
  input  logic          mw_wr_en,
  input  logic [RW-1:0] mw_dst,
  input  logic [DW-1:0] mw_wdata,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int NO = N_OPND;

  logic [RW-1:0] src_v [NO];
  logic [DW-1:0] rf_v  [NO];
  logic [DW-1:0] out_v [NO];
  fwd_sel_e      sel_v [NO];
  logic          hxm   [NO];
  logic          hmw   [NO];

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = rf_val_a;
  assign rf_v[1]  = rf_val_b;

  for (genvar g = 0; g < NO; g++) begin : g_opnd
    fwd_match #(.REG_W(RW)) u_hit_xm (
      .wr_en (xm_wr_en),
      .dst   (xm_dst),
      .src   (src_v[g]),
      .hit   (hxm[g])
    );

    fwd_match #(.REG_W(RW)) u_hit_mw (
      .wr_en (mw_wr_en),
      .dst   (mw_dst),
      .src   (src_v[g]),
      .hit   (hmw[g])
    );

    fwd_pick u_pick (
      .hit_xm (hxm[g]),
      .hit_mw (hmw[g]),
      .sel    (sel_v[g])
    );

    fwd_mux #(.DATA_W(DW)) u_mux (
      .sel     (sel_v[g]),
      .rf_val  (rf_v[g]),
      .xm_val  (xm_result),
      .mw_val  (mw_wdata),
      .out_val (out_v[g])
    );

    // Output-versus-port relations for this operand.
    always_comb begin
      // R1, R2: an execute/memory select implies a live matching producer and its value.
      assert_xm_source_R1: assert (sel_v[g] != SEL_XM ||
        (xm_wr_en && xm_dst != '0 && xm_dst == src_v[g] && out_v[g] == xm_result))
        else $error("execute/memory select without live match");
      // R3: a memory/writeback select implies its own match and its value.
      assert_mw_source_R3: assert (sel_v[g] != SEL_MW ||
        (mw_wr_en && mw_dst != '0 && mw_dst == src_v[g] && out_v[g] == mw_wdata))
        else $error("memory/writeback select without live match");
      // R4: when both producers match, the newer one wins.
      assert_newer_wins_R4: assert (!(xm_wr_en && mw_wr_en && xm_dst == mw_dst &&
        xm_dst != '0 && xm_dst == src_v[g]) || sel_v[g] == SEL_XM)
        else $error("older producer chosen over newer");
      // R5: register 0 is never forwarded.
      assert_reg0_local_R5: assert (src_v[g] != '0 || sel_v[g] == SEL_RF)
        else $error("forwarded register zero");
      // R8: code 11 never appears, and a register-file select passes the read value.
      assert_code_legal_R8: assert (sel_v[g] != 2'b11 &&
        (sel_v[g] != SEL_RF || out_v[g] == rf_v[g]))
        else $error("illegal select or wrong default value");
    end
  end

  assign fwd_sel_a = sel_v[0];
  assign fwd_sel_b = sel_v[1];
  assign opnd_a    = out_v[0];
  assign opnd_b    = out_v[1];
endmodule

// File: tb/operand_fwd_unit_tb_top.sv
module operand_fwd_unit_tb_top;
  logic clk;
  logic rst_n;

  logic [4:0]  ex_src_a, ex_src_b, xm_dst, mw_dst;
  logic [31:0] rf_val_a, rf_val_b, xm_result, mw_wdata;
  logic        xm_wr_en, mw_wr_en;
  logic [1:0]  fwd_sel_a, fwd_sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  operand_fwd_unit dut_i (
    .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
    .rf_val_a (rf_val_a), .rf_val_b (rf_val_b),
    .xm_wr_en (xm_wr_en), .xm_dst (xm_dst), .xm_result (xm_result),
    .mw_wr_en (mw_wr_en), .mw_dst (mw_dst), .mw_wdata (mw_wdata),
    .fwd_sel_a (fwd_sel_a), .fwd_sel_b (fwd_sel_b),
    .opnd_a (opnd_a), .opnd_b (opnd_b)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;   // 200 MHz

  // Behavioural reference: returns 2 for newer, 1 for older, 0 for the register file.
  function automatic int ref_code(int src, bit xw, int xd, bit mw, int md);
    if (xw && xd != 0 && xd == src) return 2;
    if (mw && md != 0 && md == src) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_val(int code, logic [31:0] rf);
    if (code == 2) return xm_result;
    if (code == 1) return mw_wdata;
    return rf;
  endfunction

  task automatic check_all(string tag);
    int ea, eb;
    logic [31:0] va, vb;
    ea = ref_code(ex_src_a, xm_wr_en, xm_dst, mw_wr_en, mw_dst);
    eb = ref_code(ex_src_b, xm_wr_en, xm_dst, mw_wr_en, mw_dst);
    va = ref_val(ea, rf_val_a);
    vb = ref_val(eb, rf_val_b);
    total++;
    if (fwd_sel_a !== ea[1:0] || fwd_sel_b !== eb[1:0] ||
        opnd_a !== va || opnd_b !== vb) begin
      bad++;
      $display("FAIL %s sel_a=%0d/%0d sel_b=%0d/%0d opnd_a=%h/%h opnd_b=%h/%h (actual/expected)",
               tag, fwd_sel_a, ea, fwd_sel_b, eb, opnd_a, va, opnd_b, vb);
    end
  endtask

  // Directed vector: drive after the falling edge, judge one ns later in the same cycle (R9).
  task automatic vec(string tag, int sa, int sb, bit xw, int xd, bit mw, int md);
    @(negedge clk);
    ex_src_a = sa[4:0]; ex_src_b = sb[4:0];
    rf_val_a = 32'hC000_0000 + sa; rf_val_b = 32'hC100_0000 + sb;
    xm_wr_en = xw; xm_dst = xd[4:0]; xm_result = 32'hA000_0000 + xd;
    mw_wr_en = mw; mw_dst = md[4:0]; mw_wdata  = 32'hB000_0000 + md;
    #1;
    check_all(tag);
  endtask

  // Instruction stream: destination, sources, write enable.
  typedef struct { int d; int s; int t; bit w; } instr_t;
  instr_t prog[$];

  task automatic run_stream();
    instr_t bub;
    instr_t xm_i, mw_i;
    bub = '{0, 0, 0, 1'b0};
    xm_i = bub; mw_i = bub;
    foreach (prog[k]) begin
      @(negedge clk);
      ex_src_a = prog[k].s[4:0]; ex_src_b = prog[k].t[4:0];
      rf_val_a = 32'hD000_0000 + k; rf_val_b = 32'hD100_0000 + k;
      xm_wr_en = xm_i.w; xm_dst = xm_i.d[4:0]; xm_result = 32'hA100_0000 + k;
      mw_wr_en = mw_i.w; mw_dst = mw_i.d[4:0]; mw_wdata  = 32'hB100_0000 + k;
      #1;
      check_all("R7 stream");
      mw_i = xm_i;
      xm_i = prog[k];
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    ex_src_a = 0; ex_src_b = 0; rf_val_a = 32'h1111_1111; rf_val_b = 32'h2222_2222;
    xm_wr_en = 0; xm_dst = 0; xm_result = 0; mw_wr_en = 0; mw_dst = 0; mw_wdata = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check_all("R8 reset idle");

    vec("R1 newer to A",            2, 5, 1, 2, 0, 0);
    vec("R2 newer to B",            6, 2, 1, 2, 0, 0);
    vec("R3 older to B",            6, 2, 0, 0, 1, 2);
    vec("R3 older to A",            9, 4, 1, 7, 1, 9);
    vec("R4 both match A",          1, 3, 1, 1, 1, 1);
    vec("R4 both match A and B",    8, 8, 1, 8, 1, 8);
    vec("R5 dest zero newer",       0, 0, 1, 0, 0, 0);
    vec("R5 dest zero both",        0, 4, 1, 0, 1, 0);
    vec("R6 newer write off",       3, 6, 0, 3, 0, 0);
    vec("R6 newer off older wins",  3, 6, 0, 3, 1, 3);
    vec("R6 older write off",       5, 5, 0, 0, 0, 5);
    vec("R7 split stages",          4, 7, 1, 4, 1, 7);
    vec("R7 split reversed",       12, 31, 1, 31, 1, 12);
    vec("R8 no match",             10, 11, 1, 12, 1, 13);
    vec("R9 max register",         31, 31, 1, 31, 1, 30);

    // Back-to-back, one gap, window exit, double hazard, zero dest, non-writer.
    prog.push_back('{2, 1, 3, 1'b1});
    prog.push_back('{12, 2, 5, 1'b1});
    prog.push_back('{13, 6, 2, 1'b1});
    prog.push_back('{14, 2, 2, 1'b1});
    prog.push_back('{0, 2, 14, 1'b0});
    prog.push_back('{1, 1, 2, 1'b1});
    prog.push_back('{1, 1, 3, 1'b1});
    prog.push_back('{1, 1, 4, 1'b1});
    prog.push_back('{0, 1, 1, 1'b1});
    prog.push_back('{7, 0, 1, 1'b0});
    prog.push_back('{9, 7, 0, 1'b1});
    prog.push_back('{4, 9, 7, 1'b1});
    run_stream();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule